// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the address used by each access of a four-beat burst. A command that arrives with the step control low loads the external address as the start of a new burst. A command with the step control high ignores the external address and advances an internal 2-bit beat counter. The generator then builds the access address from the stored upper bits and a remapped copy of the stored low two bits.

The low two bits follow one of two orders, chosen by a burst-order input that is normally tied to a fixed level. The linear order counts up modulo four. The interleaved order XORs the start bits with the beat number. Either way the burst stays inside its aligned block of four addresses, and the counter wraps, so the fifth access of an unbroken burst returns to the start address.

The access address and its valid flag are registered and appear one clock after the command.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, `acc_valid` is 0 and `acc_addr` is 0.
- R2: `acc_valid` is high exactly one clock after a cycle with `cmd_valid` high. The `acc_addr` for that command is presented in the same cycle as `acc_valid`.
- R3: A command with `step` = 0 (load) presents `ext_addr` unchanged as `acc_addr` and sets the beat number to 0.
- R4: A command with `step` = 1 (advance) increments the beat number modulo 4 and presents the address generated from it, not `ext_addr`.
- R5: After a load followed by four advances, the fourth advance presents the loaded address again.
- R6: With `order_sel` = 0 (linear), the low two bits of `acc_addr` equal (start low bits + beat) mod 4, for example 01, 10, 11, 00.
- R7: With `order_sel` = 1 (interleaved), the low two bits of `acc_addr` equal start low bits XOR beat, for example 01, 00, 11, 10 and 10, 11, 00, 01 and 11, 10, 01, 00.
- R8: During advances, bits above bit 1 of `acc_addr` equal those of the last loaded address, whatever `ext_addr` carries.
- R9: Advances issued after reset with no load count from a start address of 0.
- R10: A load in the middle of a burst restarts the beat number at 0 from the new address.
- R11: In a cycle with `cmd_valid` = 0, the start address, the beat number and `acc_addr` do not change. An advance after such an idle cycle continues from the beat reached before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present in this cycle |
| step | input | 1 | 0 = load `ext_addr` as the start, 1 = advance the beat |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| ext_addr | input | ADDR_W | External address, used only on load |
| acc_valid | output | 1 | Registered: a generated address is presented |
| acc_addr | output | ADDR_W | Registered address for the access |

## Verification
The hardest case to reach from the ports is the counter state carried across gaps. This covers an advance with no load since reset, an idle cycle in the middle of a burst, and a reload before the wrap. The stimulus reaches each one by inserting idle cycles, reloads and ext_addr noise inside running bursts, and by starting with advances straight after reset. The wrap and both orders are exercised for every start value of the low bits.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Width of the beat counter; four beats per burst
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] start_q
);
  always_ff @(posedge clk) begin
    if (rst) start_q <= '0;
    else if (load_en) start_q <= load_addr;
  end

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> start_q == $past(load_addr));

  // R11
  start_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(start_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_nxt
);
  always_comb begin
    if (clr)      beat_nxt = '0;
    else if (inc) beat_nxt = beat_q + 1'b1;
    else          beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end

  // R4
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));

  // R10
  beat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> beat_q == '0);

  // R11
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  order_e            order,
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] addr_lo
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign lin_lo = start_lo + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_lo[b] = start_lo[b] ^ beat[b];
  end

  assign addr_lo = (order == ORD_XOR) ? xor_lo : lin_lo;

  // R5: beat zero maps to the start in either order
  always_comb begin
    if (beat == '0) begin
      beat_zero_chk: assert (addr_lo == start_lo);
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              step,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              load_en;
  logic              adv_en;
  logic [ADDR_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] gen_lo;
  logic [ADDR_W-1:0] gen_addr;
  order_e            order;

  assign load_en = cmd_valid && !step;
  assign adv_en  = cmd_valid && step;
  assign order   = order_e'(order_sel);

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_addr(ext_addr),
    .start_q  (start_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk     (clk),
    .rst     (rst),
    .clr     (load_en),
    .inc     (adv_en),
    .beat_q  (beat_q),
    .beat_nxt(beat_nxt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order   (order),
    .start_lo(start_q[BEAT_W-1:0]),
    .beat    (beat_nxt),
    .addr_lo (gen_lo)
  );

  assign gen_addr = {start_q[ADDR_W-1:BEAT_W], gen_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_addr  <= '0;
    end else begin
      acc_valid <= cmd_valid;
      if (load_en)     acc_addr <= ext_addr;
      else if (adv_en) acc_addr <= gen_addr;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> acc_valid);

  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !acc_valid);

  // R3
  load_pass_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> acc_addr == $past(ext_addr));

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> acc_addr[ADDR_W-1:BEAT_W] == $past(acc_addr[ADDR_W-1:BEAT_W]));

  // R11
  addr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(acc_addr));

  initial begin
    // R8: the address must hold bits above the beat field
    width_ok_chk: assert (HI_W >= 1);
  end
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int unsigned AW = 20;

  typedef struct {
    logic          vld;
    logic [AW-1:0] addr;
    string         req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          step = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  item_t q[$];

  // model state
  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_beat = '0;
  logic [AW-1:0] m_out = '0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .step(step),
    .order_sel(order_sel), .ext_addr(ext_addr),
    .acc_valid(acc_valid), .acc_addr(acc_addr)
  );

  task automatic drive(input bit v, input bit s, input bit o,
                       input logic [AW-1:0] a, input string req);
    item_t it;
    @(negedge clk);
    cmd_valid = v; step = s; order_sel = o; ext_addr = a;
    if (v) begin
      if (!s) begin
        m_start = a; m_beat = 2'd0; m_out = a;
      end else begin
        m_beat = m_beat + 2'd1;
        m_out  = {m_start[AW-1:2],
                  o ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat)};
      end
    end
    it.vld = v; it.addr = m_out; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input string req);
    drive(1'b0, 1'b0, 1'b0, $urandom(), req);
  endtask

  always @(posedge clk) begin
    #5;
    if (mon_en && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      n_cmp++;
      if (acc_valid !== e.vld || acc_addr !== e.addr) begin
        n_bad++;
        $display("FAIL %s: got vld=%0b addr=%h, expected vld=%0b addr=%h",
                 e.req, acc_valid, acc_addr, e.vld, e.addr);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    n_cmp++;
    if (acc_valid !== 1'b0 || acc_addr !== '0) begin
      n_bad++;
      $display("FAIL R1: got vld=%0b addr=%h, expected vld=0 addr=0",
               acc_valid, acc_addr);
    end
    rst = 1'b0;
    mon_en = 1'b1;
    // R1: first cycle after reset, no command yet
    idle("R1");
    // R9: advances with no load count from zero
    drive(1, 1, 0, 20'hABCDE, "R9");
    drive(1, 1, 0, 20'h12345, "R9");
    drive(1, 1, 1, 20'h0FFFF, "R9");
    // R6, R5: linear from 01, four advances wrap to start
    drive(1, 0, 0, 20'h55551, "R3");
    for (int k = 0; k < 4; k++) drive(1, 1, 0, $urandom(), k == 3 ? "R5" : "R6");
    // R7: interleaved from every start value, with wrap
    for (int s = 0; s < 4; s++) begin
      a = {18'($urandom()), 2'(s)};
      drive(1, 0, 1, a, "R3");
      for (int k = 0; k < 4; k++) drive(1, 1, 1, $urandom(), k == 3 ? "R5" : "R7");
    end
    // R6: linear from every start value
    for (int s = 0; s < 4; s++) begin
      a = {18'($urandom()), 2'(s)};
      drive(1, 0, 0, a, "R3");
      for (int k = 0; k < 4; k++) drive(1, 1, 0, ~a, "R6");
    end
    // R11: idle cycles in the middle of a burst keep the beat
    drive(1, 0, 0, 20'h3C3C2, "R3");
    drive(1, 1, 0, 20'h00000, "R4");
    idle("R11");
    idle("R11");
    drive(1, 1, 0, 20'hFFFFF, "R11");
    drive(1, 1, 0, 20'hFFFFF, "R11");
    // R10: reload mid-burst restarts from new start
    drive(1, 0, 1, 20'h7A5A3, "R3");
    drive(1, 1, 1, 20'h00000, "R7");
    drive(1, 0, 1, 20'h11110, "R10");
    drive(1, 1, 1, 20'h22222, "R10");
    drive(1, 1, 1, 20'h33333, "R10");
    // R8: upper bits unaffected by ext_addr noise during advances
    drive(1, 0, 0, 20'hF0F03, "R3");
    for (int k = 0; k < 6; k++) drive(1, 1, 0, $urandom(), "R8");
    // R2: quiet cycles drop valid
    idle("R2");
    drive(1, 0, 0, 20'h00001, "R2");
    idle("R2");
    idle("R2");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule